// File: doc/BRIEF.md
# Parallel Host Port with Word Memory and Two-Way Mailbox

This block is a slave port through which an external processor reaches an on-chip word memory and exchanges messages with a local agent. The processor sees a window of four 16-bit registers. It selects one with two address lines and accesses it with active-low select, read and write strobes. A data-port register streams words to and from memory through an auto-incrementing byte pointer. A mailbox register carries words in both directions. A pointer register loads or reads that pointer. A status register reports the mailbox flags and holds a byte-swap enable.

The external strobes are asynchronous. Each one passes through a two-flop synchronizer, and edges are detected in the internal clock domain. An access takes effect when the strobe is released. While a read strobe is held low, the selected value is fetched into an output register, and the pad driver is enabled only while select and read are both low. The internal agent posts outgoing words, which raise an interrupt line. It receives incoming words through a data bus and a one-cycle strobe, and clears its incoming flag with a take pulse.

Top module: `host_port_bridge`

## Requirements
- R1: `ext_data_oe` is 1 exactly while `ext_cs_n` and `ext_rd_n` are both 0, and is 0 otherwise.
- R2: `ext_addr` selects the register: 2'b00 memory data port, 2'b01 mailbox, 2'b10 pointer, 2'b11 status.
- R3: An access commits only after its strobe rises again. While the write strobe is still held low, a mailbox write produces no `agent_in_strobe`.
- R4: The pointer is a byte address. Writing the pointer register loads it with bit 0 forced to 0. Each committed data-port read or write adds 2, and reading the pointer register returns the value zero-extended.
- R5: The pointer wraps from 2*MEM_WORDS-2 to 0 when it advances.
- R6: Every memory word can be written and read back through the data port. A read returns the word at the pointer as it stood before the access.
- R7: While status bit 2 is 1, data-port writes store the operand with its two bytes exchanged, and data-port reads return the stored word with its bytes exchanged.
- R8: One cycle after an `agent_post` pulse, `ext_irq` is 1. A committed mailbox read returns the posted word and clears `ext_irq`.
- R9: A committed mailbox write places the word on `agent_in_data` and pulses `agent_in_strobe` for exactly one cycle. The incoming-full flag stays set until `agent_in_take`.
- R10: Status read value is {13'b0, swap enable (bit 2), incoming full (bit 1), outgoing full (bit 0)`}`. Writing the status register loads only bit 2.
- R11: After reset, `ext_irq` is 0, status reads 0 and the pointer reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_addr | input | 2 | Register select |
| ext_data_in | input | 16 | Write data from the external bus |
| ext_data_out | output | 16 | Read data toward the external bus |
| ext_data_oe | output | 1 | Output enable for the bus driver |
| ext_irq | output | 1 | Outgoing mailbox has a word |
| agent_post | input | 1 | Agent posts an outgoing word (one-cycle pulse) |
| agent_post_data | input | 16 | Outgoing word |
| agent_take | input | 1 | Agent consumed the incoming word |
| agent_in_data | output | 16 | Last incoming mailbox word |
| agent_in_strobe | output | 1 | One-cycle pulse on a new incoming word |

## Verification
A wrong pointer appears at the ports on the next data-port or pointer read, either as a word from the wrong address or as a wrong readback value. The bench therefore fills the entire memory, reads it back and reads the pointer again after each boundary crossing. A wrong mailbox flag appears in the status word and on the interrupt within a few cycles of the triggering strobe release or agent pulse. A wrong swap setting corrupts the very next data-port word in a way that can be detected.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_MBOX = 2'b01,
    SEL_PTR  = 2'b10,
    SEL_STAT = 2'b11
  } port_sel_e;

  function automatic logic [15:0] swap_bytes(input logic [15:0] w, input logic en);
    return en ? {w[7:0], w[15:8]} : w;
  endfunction

  function automatic logic [15:0] status_word(input logic out_full, input logic in_full,
                                              input logic swap_en);
    return {13'b0, swap_en, in_full, out_full};
  endfunction

endpackage

// File: rtl/hpb_strobe_sync.sv
module hpb_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_active,
  output logic rd_commit,
  output logic wr_commit
);
  logic [2:0] chain [SYNC_STAGES];
  logic       rd_prev, wr_prev, wr_active;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[g] <= 3'b111;
      else if (g == 0) chain[g] <= {cs_n, rd_n, wr_n};
      else             chain[g] <= chain[g-1];
    end
  end

  assign rd_active = ~chain[SYNC_STAGES-1][2] & ~chain[SYNC_STAGES-1][1];
  assign wr_active = ~chain[SYNC_STAGES-1][2] & ~chain[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_active;
      wr_prev <= wr_active;
    end
  end

  assign rd_commit = rd_prev & ~rd_active;
  assign wr_commit = wr_prev & ~wr_active;

  assert_commit_after_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_commit | wr_commit) |-> $past(rd_active | wr_active));
endmodule

// File: rtl/hpb_word_ram.sv
module hpb_word_ram #(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [15:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [15:0]      rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/hpb_mailbox.sv
module hpb_mailbox (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        post,
  input  logic [15:0] post_data,
  input  logic        take,
  input  logic        ext_rd_commit,
  input  logic        ext_wr_commit,
  input  logic [15:0] ext_wdata,
  output logic [15:0] out_word,
  output logic        out_full,
  output logic [15:0] in_word,
  output logic        in_full,
  output logic        in_strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_full  <= 1'b0;
      in_word   <= '0;
      in_full   <= 1'b0;
      in_strobe <= 1'b0;
    end else begin
      if (post) begin
        out_word <= post_data;
        out_full <= 1'b1;
      end else if (ext_rd_commit) begin
        out_full <= 1'b0;
      end
      in_strobe <= ext_wr_commit;
      if (ext_wr_commit) begin
        in_word <= ext_wdata;
        in_full <= 1'b1;
      end else if (take) begin
        in_full <= 1'b0;
      end
    end
  end

  assert_post_raises_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    post |=> out_full);
  assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd_commit && !post) |=> !out_full);
  assert_strobe_with_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |-> in_full);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |=> (!in_strobe || $past(ext_wr_commit)));
endmodule

// File: rtl/host_port_bridge.sv
module host_port_bridge #(
  parameter int MEM_WORDS   = 64,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(MEM_WORDS),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_cs_n,
  input  logic        ext_rd_n,
  input  logic        ext_wr_n,
  input  logic [1:0]  ext_addr,
  input  logic [15:0] ext_data_in,
  output logic [15:0] ext_data_out,
  output logic        ext_data_oe,
  output logic        ext_irq,
  input  logic        agent_post,
  input  logic [15:0] agent_post_data,
  input  logic        agent_take,
  output logic [15:0] agent_in_data,
  output logic        agent_in_strobe
);
  import hpb_pkg::*;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return p + PTR_W'(2);
  endfunction

  logic              rd_active, rd_commit, wr_commit;
  port_sel_e         sel_q;
  logic [15:0]       din_q, dout_q, mem_rdata, rd_mux, out_word;
  logic [PTR_W-1:0]  ptr_q;
  logic              swap_en, out_full, in_full;
  logic              data_rd_commit, data_wr_commit, mbox_rd_commit, mbox_wr_commit;

  hpb_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(ext_cs_n), .rd_n(ext_rd_n), .wr_n(ext_wr_n),
    .rd_active(rd_active), .rd_commit(rd_commit), .wr_commit(wr_commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_DATA;
      din_q <= '0;
    end else begin
      sel_q <= port_sel_e'(ext_addr);
      din_q <= ext_data_in;
    end
  end

  assign data_rd_commit = rd_commit && sel_q == SEL_DATA;
  assign data_wr_commit = wr_commit && sel_q == SEL_DATA;
  assign mbox_rd_commit = rd_commit && sel_q == SEL_MBOX;
  assign mbox_wr_commit = wr_commit && sel_q == SEL_MBOX;

  hpb_word_ram #(.WORDS(MEM_WORDS)) u_ram (
    .clk(clk), .we(data_wr_commit), .widx(ptr_q[PTR_W-1:1]),
    .wdata(swap_bytes(din_q, swap_en)), .ridx(ptr_q[PTR_W-1:1]), .rdata(mem_rdata)
  );

  hpb_mailbox u_mbox (
    .clk(clk), .rst_n(rst_n), .post(agent_post), .post_data(agent_post_data),
    .take(agent_take), .ext_rd_commit(mbox_rd_commit), .ext_wr_commit(mbox_wr_commit),
    .ext_wdata(din_q), .out_word(out_word), .out_full(out_full),
    .in_word(agent_in_data), .in_full(in_full), .in_strobe(agent_in_strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      swap_en <= 1'b0;
    end else begin
      if (data_rd_commit || data_wr_commit)
        ptr_q <= step_ptr(ptr_q);
      else if (wr_commit && sel_q == SEL_PTR)
        ptr_q <= {din_q[PTR_W-1:1], 1'b0};
      if (wr_commit && sel_q == SEL_STAT)
        swap_en <= din_q[2];
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_DATA: rd_mux = swap_bytes(mem_rdata, swap_en);
      SEL_MBOX: rd_mux = out_word;
      SEL_PTR:  rd_mux = 16'(ptr_q);
      default:  rd_mux = status_word(out_full, in_full, swap_en);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dout_q <= '0;
    else if (rd_active) dout_q <= rd_mux;
  end

  assign ext_data_out = dout_q;
  assign ext_data_oe  = ~ext_cs_n & ~ext_rd_n;
  assign ext_irq      = out_full;

  assert_no_drive_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs_n || ext_rd_n) |-> !ext_data_oe);
  assert_ptr_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_commit || data_wr_commit) |=> (PTR_W'(ptr_q - $past(ptr_q)) == PTR_W'(2)));
  assert_ptr_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_q[0]);
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_commit || wr_commit) |=> $stable(ptr_q));
  assert_irq_follows_post_R8: assert property (@(posedge clk) disable iff (!rst_n)
    agent_post |=> ext_irq);
endmodule

// File: tb/test_host_port_bridge.sv
module test_host_port_bridge;
  localparam int WORDS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_cs_n = 1'b1, ext_rd_n = 1'b1, ext_wr_n = 1'b1;
  logic [1:0]  ext_addr = 2'b00;
  logic [15:0] ext_data_in = '0;
  logic [15:0] ext_data_out, agent_in_data;
  logic        ext_data_oe, ext_irq, agent_in_strobe;
  logic        agent_post = 1'b0, agent_take = 1'b0;
  logic [15:0] agent_post_data = '0;

  int checks = 0, errors = 0, strobe_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  host_port_bridge #(.MEM_WORDS(WORDS)) i_host_port_bridge (
    .clk(clk), .rst_n(rst_n), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_addr(ext_addr), .ext_data_in(ext_data_in), .ext_data_out(ext_data_out),
    .ext_data_oe(ext_data_oe), .ext_irq(ext_irq), .agent_post(agent_post),
    .agent_post_data(agent_post_data), .agent_take(agent_take),
    .agent_in_data(agent_in_data), .agent_in_strobe(agent_in_strobe)
  );

  always @(negedge clk) if (agent_in_strobe) strobe_cnt++;

  function automatic logic [15:0] pattern(input int i);
    return 16'hA500 ^ 16'(i * 16'h0111);
  endfunction

  function automatic logic [15:0] exch(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    ext_addr = a; ext_data_in = d;
    @(negedge clk);
    ext_cs_n = 1'b0; ext_wr_n = 1'b0;
    repeat (6) @(negedge clk);
    ext_wr_n = 1'b1; ext_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    ext_addr = a;
    @(negedge clk);
    ext_cs_n = 1'b0; ext_rd_n = 1'b0;
    repeat (6) @(negedge clk);
    d = ext_data_out;
    check("R1 oe during read", 16'(ext_data_oe), 16'd1);
    ext_rd_n = 1'b1; ext_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check("R11 irq after reset", 16'(ext_irq), 16'd0);
    bus_read(2'b11, v); check("R11 status after reset", v, 16'h0000);
    bus_read(2'b10, v); check("R11 pointer after reset", v, 16'h0000);

    check("R1 idle oe", 16'(ext_data_oe), 16'd0);
    @(negedge clk); ext_cs_n = 1'b0;
    @(negedge clk); check("R1 cs only oe", 16'(ext_data_oe), 16'd0);
    ext_cs_n = 1'b1; ext_rd_n = 1'b0;
    @(negedge clk); check("R1 rd only oe", 16'(ext_data_oe), 16'd0);
    ext_rd_n = 1'b1;

    // R6 full fill and readback; R5 wrap after the last word
    bus_write(2'b10, 16'h0000);
    for (int i = 0; i < WORDS; i++) bus_write(2'b00, pattern(i));
    bus_read(2'b10, v); check("R5 pointer wrapped after fill", v, 16'h0000);
    for (int i = 0; i < WORDS; i++) begin
      bus_read(2'b00, v); check("R6 readback", v, pattern(i));
    end

    // R4 load, odd address forced even, advance by 2
    bus_write(2'b10, 16'h000B);
    bus_read(2'b10, v); check("R4 pointer load even", v, 16'h000A);
    bus_read(2'b00, v); check("R2 data port word 5", v, pattern(5));
    bus_read(2'b10, v); check("R4 pointer advanced", v, 16'h000C);
    bus_write(2'b00, 16'h7E81);
    bus_read(2'b10, v); check("R4 pointer after write", v, 16'h000E);
    bus_write(2'b10, 16'h000C);
    bus_read(2'b00, v); check("R6 overwritten word 6", v, 16'h7E81);

    // R5 wrap from top
    bus_write(2'b10, 16'(2 * WORDS - 2));
    bus_read(2'b00, v); check("R5 top word", v, pattern(WORDS - 1));
    bus_read(2'b10, v); check("R5 wrap to zero", v, 16'h0000);

    // R7 swap both directions; R10 status bit 2
    bus_write(2'b11, 16'hFFFC);
    bus_read(2'b11, v); check("R10 status swap only", v, 16'h0004);
    bus_write(2'b10, 16'h0000);
    bus_read(2'b00, v); check("R7 swapped read", v, exch(pattern(0)));
    bus_write(2'b10, 16'h0004);
    bus_write(2'b00, 16'h1234);
    bus_write(2'b11, 16'h0000);
    bus_write(2'b10, 16'h0004);
    bus_read(2'b00, v); check("R7 swapped write stored", v, 16'h3412);
    bus_read(2'b11, v); check("R10 swap cleared", v, 16'h0000);

    // R8 outgoing mailbox
    check("R8 irq idle", 16'(ext_irq), 16'd0);
    @(negedge clk); agent_post = 1'b1; agent_post_data = 16'hBEEF;
    @(negedge clk); agent_post = 1'b0;
    check("R8 irq after post", 16'(ext_irq), 16'd1);
    bus_read(2'b11, v); check("R10 outgoing full bit", v, 16'h0001);
    bus_read(2'b01, v); check("R8 mailbox word", v, 16'hBEEF);
    check("R8 irq cleared by read", 16'(ext_irq), 16'd0);

    // R3 / R9 incoming mailbox
    @(negedge clk); ext_addr = 2'b01; ext_data_in = 16'h5A5A;
    @(negedge clk); ext_cs_n = 1'b0; ext_wr_n = 1'b0;
    repeat (8) @(negedge clk);
    check("R3 no strobe while held", 16'(strobe_cnt), 16'd0);
    ext_wr_n = 1'b1; ext_cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R9 single strobe", 16'(strobe_cnt), 16'd1);
    check("R9 agent data", agent_in_data, 16'h5A5A);
    @(negedge clk); agent_post = 1'b1; agent_post_data = 16'h0F0F;
    @(negedge clk); agent_post = 1'b0;
    bus_read(2'b11, v); check("R10 both full", v, 16'h0003);
    @(negedge clk); agent_take = 1'b1;
    @(negedge clk); agent_take = 1'b0;
    bus_read(2'b11, v); check("R9 take clears incoming", v, 16'h0001);
    bus_read(2'b01, v); check("R8 second word", v, 16'h0F0F);
    bus_read(2'b11, v); check("R10 all clear", v, 16'h0000);
    check("R9 no extra strobe", 16'(strobe_cnt), 16'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule